// File: doc/BRIEF.md
# Supply monitor reset sequencer

This block turns three digitized supply comparator flags into the control signals that protect a battery-backed memory and hold a processor in reset while the main supply is unfit. The flags say whether the supply sits above the out-of-tolerance trip level, above the battery voltage, and above the backup switch-over level. From them the block drives a write-protect line, a select between main and backup source, a memory-ready flag and an active-low processor reset.

A drop below the trip level protects the memory and asserts reset on the next clock edge. Reset stays asserted for the whole descent: through the band down to the battery level, below it, and until the supply has come back. On the way up, the supply must stay above the trip level without a break. After the recovery delay, memory access is allowed. After a longer reset timeout, counted from the same moment, the processor is released. Any dip below the trip level restarts both delays.

The backup source is never selected until the supply has crossed the trip level for the first time after reset. This keeps the cell disconnected while the part is on the shelf. A test-mode shipping input returns the block to that state. Both delays are parameters in clock cycles. Elaboration stops if the reset timeout is not longer than the recovery delay.

Top module: `supply_monitor_seq`

## Requirements
- R1: While reset is applied and before any flag rises, `wr_protect`=1, `use_backup`=0, `mem_ready`=0 and `cpu_rst_n`=0.
- R2: Inconsistent flags are resolved by the highest level asserted, in the order trip > battery > switch-over. A set battery flag with a clear switch-over flag therefore counts as above switch-over.
- R3: In the cycle after a clock edge samples `above_trip`=0, `wr_protect`=1, `mem_ready`=0 and `cpu_rst_n`=0. This holds regardless of the other flags.
- R4: `use_backup` is 1 only while no flag is set, and it is 0 in the cycle after any flag is sampled high.
- R5: `mem_ready` rises exactly REC_CYCLES+1 edges after the first edge that samples `above_trip`=1 following a low period, provided `above_trip` stays high. `wr_protect` is always the inverse of `mem_ready`.
- R6: `cpu_rst_n` rises exactly TMO_CYCLES+1 edges after that same first edge, with `above_trip` held high throughout.
- R7: `cpu_rst_n`=1 implies `mem_ready`=1. Reset is therefore never released while the memory is protected.
- R8: A single low sample of `above_trip` during either delay restarts both delays from zero. The full REC_CYCLES+1 and TMO_CYCLES+1 edge counts then apply again from the next high sample.
- R9: After reset, `use_backup` stays 0 for every flag pattern until an edge has sampled `above_trip`=1. After that, an all-clear pattern gives `use_backup`=1 on the next edge.
- R10: An edge that samples `ship_mode`=1 clears the backup enable, so `use_backup`=0 in the next cycle. This clearing wins over a simultaneous `above_trip`=1. The enable returns only at a later edge that samples `above_trip`=1 with `ship_mode`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| above_trip | input | 1 | Supply is above the out-of-tolerance trip level |
| above_batt | input | 1 | Supply is above the battery voltage |
| above_switch | input | 1 | Supply is above the backup switch-over level |
| ship_mode | input | 1 | Test-mode shipping request; clears the backup enable |
| wr_protect | output | 1 | Memory write protect, active high |
| use_backup | output | 1 | 1 selects the backup source, 0 the main supply |
| mem_ready | output | 1 | Memory may be accessed |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The hardest situation to reach is a restart in the middle of a delay. It needs the supply to have been high for a chosen number of edges short of the timeout, and then to be low for exactly one sample. The bench builds this with cycle-counted drives at the falling edge. It rebuilds the whole REC/TMO edge count after each dip and compares `mem_ready` and `cpu_rst_n` in every cycle. The backup enable is only visible once the supply is back below switch-over, so the bench walks all flag patterns both before and after the first trip crossing. It also runs the shipping input both alone and together with a trip sample, to show which of the two wins.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  // Ordered so that a larger value means a higher supply.
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_SW   = 2'd1,
    LVL_BATT = 2'd2,
    LVL_TRIP = 2'd3
  } level_e;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_BACKUP  = 3'd1,
    ST_DROOP   = 3'd2,
    ST_RECOVER = 3'd3,
    ST_TIMEOUT = 3'd4,
    ST_NORMAL  = 3'd5
  } state_e;

  typedef struct packed {
    logic wp;
    logic backup;
    logic ready;
    logic cpu_rst_n;
  } outs_t;

  function automatic outs_t decode_state(state_e s);
    outs_t o;
    o = '{wp: 1'b1, backup: 1'b0, ready: 1'b0, cpu_rst_n: 1'b0};
    case (s)
      ST_BACKUP:  o.backup = 1'b1;
      ST_TIMEOUT: begin
        o.wp    = 1'b0;
        o.ready = 1'b1;
      end
      ST_NORMAL:  begin
        o.wp        = 1'b0;
        o.ready     = 1'b1;
        o.cpu_rst_n = 1'b1;
      end
      default:    ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/supmon_rst_sync.sv
module supmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/supmon_level.sv
module supmon_level
  import supmon_pkg::*;
(
  input  logic   above_trip,
  input  logic   above_batt,
  input  logic   above_switch,
  output level_e level
);

  always_comb begin
    if (above_trip)        level = LVL_TRIP;
    else if (above_batt)   level = LVL_BATT;
    else if (above_switch) level = LVL_SW;
    else                   level = LVL_LOW;
  end

endmodule

// File: rtl/supmon_delay.sv
module supmon_delay #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = (cnt_q == LAST);
  assign cnt_en = !run || !done;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/supmon_fsm.sv
module supmon_fsm
  import supmon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  level_e level,
  input  logic   ship_mode,
  input  logic   rec_done,
  input  logic   tmo_done,
  output state_e state,
  output logic   delay_run
);

  state_e state_q, state_d;
  logic   armed_q, armed_d;
  logic   armed_en;

  // Shipping request wins over a trip crossing.
  always_comb begin
    armed_d  = armed_q;
    armed_en = 1'b0;
    if (ship_mode) begin
      armed_d  = 1'b0;
      armed_en = 1'b1;
    end else if (level == LVL_TRIP) begin
      armed_d  = 1'b1;
      armed_en = 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    if (level != LVL_TRIP) begin
      if (level == LVL_LOW) state_d = armed_d ? ST_BACKUP : ST_OFF;
      else                  state_d = ST_DROOP;
    end else begin
      case (state_q)
        ST_OFF, ST_BACKUP, ST_DROOP: state_d = ST_RECOVER;
        ST_RECOVER: if (rec_done) state_d = ST_TIMEOUT;
        ST_TIMEOUT: if (tmo_done) state_d = ST_NORMAL;
        ST_NORMAL:  state_d = ST_NORMAL;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign state     = state_q;
  assign delay_run = (level == LVL_TRIP) &&
                     ((state_q == ST_RECOVER) || (state_q == ST_TIMEOUT));

endmodule

// File: rtl/supply_monitor_seq.sv
module supply_monitor_seq
  import supmon_pkg::*;
#(
  parameter int REC_CYCLES  = 2000,
  parameter int TMO_CYCLES  = 60000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_trip,
  input  logic above_batt,
  input  logic above_switch,
  input  logic ship_mode,
  output logic wr_protect,
  output logic use_backup,
  output logic mem_ready,
  output logic cpu_rst_n
);

  localparam int NUM_DELAYS = 2;

  if (TMO_CYCLES <= REC_CYCLES) begin : g_bad_timeout
    $error("reset timeout must exceed recovery delay");
  end
  if (REC_CYCLES < 2) begin : g_bad_recovery
    $error("recovery delay must be at least two cycles");
  end
  if (SYNC_STAGES < 2) begin : g_bad_sync
    $error("reset synchronizer needs at least two stages");
  end

  logic                  rst_n_int;
  level_e                level;
  state_e                state;
  logic                  delay_run;
  logic [NUM_DELAYS-1:0] delay_done;
  outs_t                 outs;

  supmon_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  supmon_level u_level (
    .above_trip   (above_trip),
    .above_batt   (above_batt),
    .above_switch (above_switch),
    .level        (level)
  );

  // Index 0: recovery delay, index 1: reset timeout. Both start together.
  for (genvar gi = 0; gi < NUM_DELAYS; gi++) begin : g_delay
    localparam int LIM = (gi == 0) ? REC_CYCLES : TMO_CYCLES;
    supmon_delay #(.LIMIT(LIM)) u_delay (
      .clk   (clk),
      .rst_n (rst_n_int),
      .run   (delay_run),
      .done  (delay_done[gi])
    );
  end

  supmon_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .level     (level),
    .ship_mode (ship_mode),
    .rec_done  (delay_done[0]),
    .tmo_done  (delay_done[1]),
    .state     (state),
    .delay_run (delay_run)
  );

  assign outs       = decode_state(state);
  assign wr_protect = outs.wp;
  assign use_backup = outs.backup;
  assign mem_ready  = outs.ready;
  assign cpu_rst_n  = outs.cpu_rst_n;

endmodule

// File: rtl/supmon_checker.sv
module supmon_checker #(
  parameter int REC_CYCLES = 2000,
  parameter int TMO_CYCLES = 60000
) (
  input logic clk,
  input logic rst_n,
  input logic above_trip,
  input logic above_batt,
  input logic above_switch,
  input logic ship_mode,
  input logic wr_protect,
  input logic use_backup,
  input logic mem_ready,
  input logic cpu_rst_n
);

  localparam int RW = $clog2(TMO_CYCLES + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(TMO_CYCLES + 1);

  logic [RW-1:0] trip_run_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    trip_run_q <= '0;
    else if (!above_trip)          trip_run_q <= '0;
    else if (trip_run_q < RUN_MAX) trip_run_q <= trip_run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (ship_mode)  seen_q <= 1'b0;
    else if (above_trip) seen_q <= 1'b1;
  end

  p_fall_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !above_trip |=> (wr_protect && !mem_ready && !cpu_rst_n));

  p_main_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (above_trip || above_batt || above_switch) |=> !use_backup);

  p_recover_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> (trip_run_q > RW'(REC_CYCLES)));

  p_protect_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect != mem_ready);

  p_timeout_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> (trip_run_q > RW'(TMO_CYCLES)));

  p_release_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> mem_ready);

  p_backup_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    use_backup |-> seen_q);

  p_ship_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ship_mode |=> !use_backup);

endmodule

bind supply_monitor_seq supmon_checker #(
  .REC_CYCLES (REC_CYCLES),
  .TMO_CYCLES (TMO_CYCLES)
) u_supmon_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .above_trip   (above_trip),
  .above_batt   (above_batt),
  .above_switch (above_switch),
  .ship_mode    (ship_mode),
  .wr_protect   (wr_protect),
  .use_backup   (use_backup),
  .mem_ready    (mem_ready),
  .cpu_rst_n    (cpu_rst_n)
);

// File: tb/tb_supply_monitor_seq.sv
module tb_supply_monitor_seq;

  localparam int REC = 4;
  localparam int TMO = 9;

  logic clk;
  logic rst_n;
  logic above_trip, above_batt, above_switch, ship_mode;
  logic wr_protect, use_backup, mem_ready, cpu_rst_n;

  int n_checks;
  int n_fails;

  supply_monitor_seq #(
    .REC_CYCLES  (REC),
    .TMO_CYCLES  (TMO),
    .SYNC_STAGES (2)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .above_trip   (above_trip),
    .above_batt   (above_batt),
    .above_switch (above_switch),
    .ship_mode    (ship_mode),
    .wr_protect   (wr_protect),
    .use_backup   (use_backup),
    .mem_ready    (mem_ready),
    .cpu_rst_n    (cpu_rst_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Output vector order: {wr_protect, use_backup, mem_ready, cpu_rst_n}
  function automatic logic [3:0] outs();
    return {wr_protect, use_backup, mem_ready, cpu_rst_n};
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    n_checks++;
    if (outs() !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: got wp/bk/rdy/rst_n=%b expected %b",
               req, $time, outs(), exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic flags(input logic t, input logic b, input logic s);
    above_trip   = t;
    above_batt   = b;
    above_switch = s;
  endtask

  // Holds trip high and checks every cycle against the edge counts.
  task automatic power_up(input string req);
    flags(1'b1, 1'b1, 1'b1);
    for (int i = 1; i <= TMO + 2; i++) begin
      logic rdy, rel;
      tick(1);
      rdy = (i >= REC + 1);
      rel = (i >= TMO + 1);
      check(req, {!rdy, 1'b0, rdy, rel});
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n = 1'b0;
    ship_mode = 1'b0;
    flags(1'b0, 1'b0, 1'b0);
    tick(3);
    check("R1 reset state", 4'b1000);
    rst_n = 1'b1;
    tick(4);
    check("R1 after release", 4'b1000);

    // R9 / R2 / R4: before the first trip crossing, backup never selected.
    for (int v = 0; v < 4; v++) begin
      flags(1'b0, v[1], v[0]);
      tick(1);
      check("R9 unarmed sweep", 4'b1000);
    end

    // R5 R6 R7: first power-up, cycle by cycle.
    power_up("R5 R6 R7 power-up");

    // R3: a drop below trip from normal operation.
    flags(1'b0, 1'b1, 1'b1);
    tick(1);
    check("R3 drop from normal", 4'b1000);

    // R8: restart in the middle of the timeout.
    flags(1'b1, 1'b1, 1'b1);
    tick(TMO - 2);
    check("R8 partial count", 4'b0010);
    flags(1'b0, 1'b1, 1'b0);
    tick(1);
    check("R3 R8 single dip", 4'b1000);
    power_up("R8 full recount");

    // R8: restart in the middle of the recovery delay.
    flags(1'b0, 1'b0, 1'b1);
    tick(1);
    flags(1'b1, 1'b1, 1'b1);
    tick(REC - 1);
    check("R8 early recovery", 4'b1000);
    flags(1'b0, 1'b0, 1'b1);
    tick(1);
    power_up("R8 recount after early dip");

    // R2 R4 R9: armed sweep over all flag patterns.
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 8; v++) begin
        logic bk;
        flags(v[2], v[1], v[0]);
        tick(1);
        bk = (v == 0);
        check("R2 R4 R9 armed sweep", {1'b1, bk, 1'b0, 1'b0});
      end
    end
    // R2: battery set, switch-over clear counts as above switch-over.
    flags(1'b0, 1'b1, 1'b0);
    tick(1);
    check("R2 battery priority", 4'b1000);

    // R10: shipping request while on backup.
    flags(1'b0, 1'b0, 1'b0);
    tick(1);
    check("R9 backup selected", 4'b1100);
    ship_mode = 1'b1;
    tick(1);
    check("R10 ship clears backup", 4'b1000);
    ship_mode = 1'b0;
    tick(1);
    check("R10 stays cleared", 4'b1000);
    flags(1'b0, 1'b1, 1'b1);
    tick(1);
    flags(1'b0, 1'b0, 1'b0);
    tick(1);
    check("R10 no rearm below trip", 4'b1000);

    // R10: shipping wins over a simultaneous trip sample.
    ship_mode = 1'b1;
    flags(1'b1, 1'b1, 1'b1);
    tick(1);
    ship_mode = 1'b0;
    flags(1'b0, 1'b0, 1'b0);
    tick(1);
    check("R10 ship beats trip", 4'b1000);

    // R9: one trip sample rearms.
    flags(1'b1, 1'b1, 1'b1);
    tick(1);
    flags(1'b0, 1'b0, 1'b0);
    tick(1);
    check("R9 rearmed", 4'b1100);

    // R1: reset mid-operation returns to the reset state.
    power_up("R6 final power-up");
    rst_n = 1'b0;
    tick(1);
    check("R1 reset from normal", 4'b1000);
    rst_n = 1'b1;
    tick(2);

    summary();
  end

endmodule